// File: doc/BRIEF.md
# Predicated Execution Gate

This block sits beside the execute stage of a simple integer pipeline. It keeps the four arithmetic condition flags: negative, zero, carry and overflow. For every instruction in execute, it decides whether that instruction may take effect. Each instruction arrives with a 4-bit condition field. The block tests that field against the stored flags in the same cycle. It then raises an execute decision and a register write-back enable, or squashes both.

When an instruction passes its test and asks to set the flags, the flags are loaded from the ALU result flags at the closing clock edge. The following instruction therefore sees the new values. A compare instruction always loads the flags when it executes, but it never writes a destination register. An instruction that fails its test is dropped without effect, so a single instruction can be skipped without a branch.

Top module: `pred_gate`

## Requirements
- R1: While reset is held, and right after it is released, `flags_o` is 4'b0000. The bit order is [3]=negative, [2]=zero, [1]=carry, [0]=overflow, and `alu_flags_i` uses the same order.
- R2: While `valid_i` is high, `exec_o` follows the condition field combinationally. The codes are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
- R3: Code 14 always executes and code 15 never executes, whatever the flags.
- R4: `wb_en_o` is high exactly when the instruction executes, `wr_req_i` is high and `cmp_i` is low.
- R5: An executing instruction with `set_flags_i` high loads `alu_flags_i` into the flags at the clock edge that ends its cycle. The next cycle sees the new value.
- R6: An executing compare (`cmp_i` high) loads the flags even with `set_flags_i` low, and never raises `wb_en_o`.
- R7: A squashed instruction leaves the flags unchanged and raises neither `exec_o` nor `wb_en_o`, even with `set_flags_i` or `cmp_i` high.
- R8: With `valid_i` low, `exec_o` and `wb_en_o` are low and the flags hold.
- R9: An executing non-compare instruction with `set_flags_i` low leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction is in execute this cycle |
| cond_i | input | 4 | Condition field of the instruction |
| set_flags_i | input | 1 | Instruction asks to update the flags |
| cmp_i | input | 1 | Instruction is a compare (flags only, no result write) |
| wr_req_i | input | 1 | Instruction has a destination register to write |
| alu_flags_i | input | 4 | ALU result flags {N,Z,C,V} |
| exec_o | output | 1 | Instruction condition holds; it commits |
| wb_en_o | output | 1 | Register write-back enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the block with its fixed widths: a 4-bit condition field and a 4-bit flag set. That keeps the whole space small enough to cover exhaustively. For every one of the 16 flag patterns it first loads the pattern through an always-executing flag-setting instruction, then applies each of the 16 condition codes, so all 256 condition/flag pairs are compared. After that, directed squash, compare, idle and no-set cases run, followed by a long random mix. Every cycle is checked against a behavioural model.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned COND_W = 4;
  localparam int unsigned FLAG_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    C_ZS  = 4'd0,
    C_ZC  = 4'd1,
    C_CS  = 4'd2,
    C_CC  = 4'd3,
    C_NS  = 4'd4,
    C_NC  = 4'd5,
    C_VS  = 4'd6,
    C_VC  = 4'd7,
    C_UGT = 4'd8,
    C_ULE = 4'd9,
    C_SGE = 4'd10,
    C_SLT = 4'd11,
    C_SGT = 4'd12,
    C_SLE = 4'd13,
    C_ALW = 4'd14,
    C_NEV = 4'd15
  } cond_e;
endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_pkg::*;
(
  input  logic [COND_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              hold_o
);
  logic sgn_ge;
  assign sgn_ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      C_ZS:    hold_o = flags_i.z;
      C_ZC:    hold_o = !flags_i.z;
      C_CS:    hold_o = flags_i.c;
      C_CC:    hold_o = !flags_i.c;
      C_NS:    hold_o = flags_i.n;
      C_NC:    hold_o = !flags_i.n;
      C_VS:    hold_o = flags_i.v;
      C_VC:    hold_o = !flags_i.v;
      C_UGT:   hold_o = flags_i.c && !flags_i.z;
      C_ULE:   hold_o = !flags_i.c || flags_i.z;
      C_SGE:   hold_o = sgn_ge;
      C_SLT:   hold_o = !sgn_ge;
      C_SGT:   hold_o = !flags_i.z && sgn_ge;
      C_SLE:   hold_o = flags_i.z || !sgn_ge;
      C_ALW:   hold_o = 1'b1;
      C_NEV:   hold_o = 1'b0;
      default: hold_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
  import pred_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   load_i,
  input  flags_t nxt_i,
  output flags_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= nxt_i;
  end
endmodule

// File: rtl/pred_gate.sv
module pred_gate
  import pred_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              set_flags_i,
  input  logic              cmp_i,
  input  logic              wr_req_i,
  input  logic [FLAG_W-1:0] alu_flags_i,
  output logic              exec_o,
  output logic              wb_en_o,
  output logic [FLAG_W-1:0] flags_o
);
  flags_t cur_flags;
  logic   cond_hold;
  logic   flag_load;

  pred_cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (cur_flags),
    .hold_o  (cond_hold)
  );

  // compare implies a flag update; a squash blocks every side effect
  assign exec_o    = valid_i && cond_hold;
  assign wb_en_o   = exec_o && wr_req_i && !cmp_i;
  assign flag_load = exec_o && (set_flags_i || cmp_i);

  pred_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (flag_load),
    .nxt_i  (flags_t'(alu_flags_i)),
    .q_o    (cur_flags)
  );

  assign flags_o = cur_flags;
endmodule

// File: rtl/pred_gate_chk.sv
module pred_gate_chk
  import pred_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [COND_W-1:0] cond_i,
  input logic              set_flags_i,
  input logic              cmp_i,
  input logic              wr_req_i,
  input logic [FLAG_W-1:0] alu_flags_i,
  input logic              exec_o,
  input logic              wb_en_o,
  input logic [FLAG_W-1:0] flags_o
);
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!exec_o && !wb_en_o));

  assert_always_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i == 4'd14) |-> exec_o);

  assert_never_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'd15) |-> !exec_o);

  assert_wb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (exec_o && wr_req_i && !cmp_i));

  assert_cmp_nowb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i |-> !wb_en_o);

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && (set_flags_i || cmp_i)) |=> (flags_o == $past(alu_flags_i)));

  assert_squash_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |=> $stable(flags_o));

  assert_noset_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && !cmp_i) |=> $stable(flags_o));
endmodule

bind pred_gate pred_gate_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .cond_i      (cond_i),
  .set_flags_i (set_flags_i),
  .cmp_i       (cmp_i),
  .wr_req_i    (wr_req_i),
  .alu_flags_i (alu_flags_i),
  .exec_o      (exec_o),
  .wb_en_o     (wb_en_o),
  .flags_o     (flags_o)
);

// File: tb/pred_gate_tb.sv
module pred_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] cond_i = 4'd0;
  logic       set_flags_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic       wr_req_i = 1'b0;
  logic [3:0] alu_flags_i = 4'd0;
  logic       exec_o;
  logic       wb_en_o;
  logic [3:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] mflags = 4'd0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pred_gate u_dut (
    .clk_i, .rst_ni, .valid_i, .cond_i, .set_flags_i, .cmp_i,
    .wr_req_i, .alu_flags_i, .exec_o, .wb_en_o, .flags_o
  );

  function automatic bit ref_cond(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !(cy && !z);
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return !(!z && (n == v));
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one instruction, compare outputs mid-cycle, advance the model
  task automatic step(input string tag, input bit v, input logic [3:0] c, input bit sf,
                      input bit cm, input bit wr, input logic [3:0] af);
    bit e_exec, e_wb;
    @(negedge clk_i);
    valid_i = v; cond_i = c; set_flags_i = sf; cmp_i = cm; wr_req_i = wr; alu_flags_i = af;
    #1;
    e_exec = v && ref_cond(c, mflags);
    e_wb   = e_exec && wr && !cm;
    chk({tag, " R2 exec"}, {3'b0, exec_o}, {3'b0, e_exec});
    chk({tag, " R4 wb"}, {3'b0, wb_en_o}, {3'b0, e_wb});
    chk({tag, " R5 flags"}, flags_o, mflags);
    if (e_exec && (sf || cm)) mflags = af;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    chk("R1 in reset", flags_o, 4'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 after reset", flags_o, 4'd0);

    // exhaustive condition x flags
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        step("R5 load", 1, 4'd14, 1, 0, 1, 4'(f));
        step((c >= 14) ? "R3 fixed" : "R2 table", 1, 4'(c), 0, 0, 1, 4'(~f));
      end
    end

    // squash: flags Z=0, EQ fails; set and compare must not touch flags
    step("R5 setup", 1, 4'd14, 1, 0, 0, 4'b0000);
    step("R7 squash set", 1, 4'd0, 1, 0, 1, 4'b1111);
    step("R7 squash cmp", 1, 4'd0, 0, 1, 0, 4'b1111);
    step("R3 never set", 1, 4'd15, 1, 1, 1, 4'b1010);
    @(negedge clk_i); #1;
    chk("R7 flags kept", flags_o, 4'b0000);

    // compare without set bit updates flags, never writes
    step("R6 cmp", 1, 4'd14, 0, 1, 1, 4'b0110);
    step("R6 cmp next", 1, 4'd0, 0, 0, 1, 4'b0000);
    chk("R6 flags loaded", flags_o, 4'b0110);

    // executing, no set bit: flags hold
    step("R9 noset", 1, 4'd14, 0, 0, 1, 4'b1001);
    step("R9 after", 1, 4'd14, 0, 0, 0, 4'b0000);
    chk("R9 flags held", flags_o, 4'b0110);

    // idle cycles: nothing happens
    step("R8 idle", 0, 4'd14, 1, 1, 1, 4'b1111);
    step("R8 idle after", 0, 4'd14, 0, 0, 0, 4'b0000);
    chk("R8 flags held", flags_o, 4'b0110);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step("rand", ($urandom_range(0, 7) != 0), 4'($urandom), r[0], r[1] & r[2],
           r[3], 4'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule